// File: doc/BRIEF.md
# Interrupt Status and Mask Register Set

This block is the interrupt front end of a serial-bus controller. It captures condition signals from the controller's datapath into a sticky status word. It also keeps an enable mask and drives a single interrupt line. Each source bit is sampled on every clock edge, and once it has been seen high it stays latched in the status word. Software removes a latched bit by writing a one to that bit position in the status register. Writing back the word it has just read therefore acknowledges exactly the events it has seen.

The mask cannot be written directly. One register address sets the mask bits written as one, and a second address clears them, so no read-modify-write sequence is needed and separate software agents cannot undo each other's changes. A third address shows the current mask for reading only. The interrupt line is high whenever any latched status bit is also enabled.

Register reads are combinational on the address bus. Status reads at byte offset 0x04, enable-set writes at 0x08, enable-clear writes at 0x0C, and the mask reads at 0x10. All four registers share one bit layout.

Top module: `irq_regs_top`

## Requirements
- R1: After reset the status word and the mask are all zeros and `irq` is low.
- R2: A source bit that is high at a rising clock edge sets its status bit, and the bit stays set after the source falls until software clears it. The source bits are: bit 1 mode fault, bit 2 transmit queue above watermark, bit 3 transmit queue full, bit 4 receive queue not empty. Bits 0, 5 and 6 are spare sources.
- R3: A write to offset 0x04 clears every status bit that is one in the written data. Status bits written as zero keep their value.
- R4: When a source bit is high in the same cycle that a write to 0x04 clears that bit, the status bit stays set.
- R5: A write to offset 0x08 sets every mask bit that is one in the data. Other mask bits are unchanged.
- R6: A write to offset 0x0C clears every mask bit that is one in the data. Other mask bits are unchanged.
- R7: A read at 0x04 returns the status word and a read at 0x10 returns the mask, with both in bits 6..0. Data bits 31..7 always read as zero, and written ones in those bits have no effect.
- R8: Reads at 0x08, at 0x0C and at any unmapped offset return zero.
- R9: `irq` is high exactly when some status bit and its mask bit are both one.
- R10: A write to 0x10 leaves the mask unchanged. Writes to 0x08 and 0x0C leave the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| srcIn | input | 7 | Source conditions (pulses or levels) from the datapath |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default values: seven sources, a 32-bit data word and an 8-bit offset bus with the register offsets listed above. With these values every source bit can be reached individually and in mixed patterns. The unused data bits 31..7 are also reachable, so the bench can show that they are dropped on writes and read back as zero. A level source is held across a clearing write to exercise the case where a set and a clear of the same bit meet in one cycle.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;

  // Write strobes from address decode to the register storage
  typedef struct packed {
    logic clrStatus;
    logic setMask;
    logic clrMask;
  } regStrobe_t;

  // Which word the read mux presents
  typedef enum logic [1:0] {
    RD_ZERO   = 2'd0,
    RD_STATUS = 2'd1,
    RD_MASK   = 2'd2
  } readSel_t;

endpackage

// File: rtl/irq_regs_ctrl.sv
module irq_regs_ctrl
  import irq_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_OFS  = 'h04,
  parameter logic [ADDR_W-1:0] ENABLE_OFS  = 'h08,
  parameter logic [ADDR_W-1:0] DISABLE_OFS = 'h0C,
  parameter logic [ADDR_W-1:0] MASK_OFS    = 'h10
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobe_t        strobe,
  output readSel_t          readSel
);

  logic hitStatus;
  logic hitEnable;
  logic hitDisable;
  logic hitMask;

  always_comb begin
    hitStatus  = (addr == STATUS_OFS);
    hitEnable  = (addr == ENABLE_OFS);
    hitDisable = (addr == DISABLE_OFS);
    hitMask    = (addr == MASK_OFS);
  end

  // Writes to the mask view are dropped: no strobe for hitMask
  always_comb begin
    strobe           = '0;
    strobe.clrStatus = wrEn && hitStatus;
    strobe.setMask   = wrEn && hitEnable;
    strobe.clrMask   = wrEn && hitDisable;
  end

  // Enable and disable addresses are write-only and read as zero
  always_comb begin
    if (hitStatus)    readSel = RD_STATUS;
    else if (hitMask) readSel = RD_MASK;
    else              readSel = RD_ZERO;
  end

endmodule

// File: rtl/irq_regs_dp.sv
module irq_regs_dp
  import irq_regs_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strobe,
  input  readSel_t           readSel,
  input  logic [NUM_SRC-1:0] wrBits,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic [NUM_SRC-1:0] statusQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [DATA_W-1:0]  rdata
);

  for (genvar g = 0; g < NUM_SRC; g++) begin : gBit
    // Sticky status: a live source beats a same-cycle clear
    always_ff @(posedge clk) begin
      if (!rstN)                              statusQ[g] <= 1'b0;
      else if (srcIn[g])                      statusQ[g] <= 1'b1;
      else if (strobe.clrStatus && wrBits[g]) statusQ[g] <= 1'b0;
    end

    // Mask: separate set and clear ports, zeros leave bits alone
    always_ff @(posedge clk) begin
      if (!rstN)                            maskQ[g] <= 1'b0;
      else if (strobe.setMask && wrBits[g]) maskQ[g] <= 1'b1;
      else if (strobe.clrMask && wrBits[g]) maskQ[g] <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (readSel)
      RD_STATUS: rdata[NUM_SRC-1:0] = statusQ;
      RD_MASK:   rdata[NUM_SRC-1:0] = maskQ;
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_regs_top.sv
module irq_regs_top
  import irq_regs_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] STATUS_OFS  = 'h04,
  parameter logic [ADDR_W-1:0] ENABLE_OFS  = 'h08,
  parameter logic [ADDR_W-1:0] DISABLE_OFS = 'h0C,
  parameter logic [ADDR_W-1:0] MASK_OFS    = 'h10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irq
);

  regStrobe_t         strobe;
  readSel_t           readSel;
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] maskQ;
  logic               unusedWdataHi;

  // Data bits above the source count carry no state
  assign unusedWdataHi = ^wdata[DATA_W-1:NUM_SRC];

  irq_regs_ctrl #(
    .ADDR_W(ADDR_W), .STATUS_OFS(STATUS_OFS), .ENABLE_OFS(ENABLE_OFS),
    .DISABLE_OFS(DISABLE_OFS), .MASK_OFS(MASK_OFS)
  ) uCtrl (
    .wrEn(wrEn), .addr(addr), .strobe(strobe), .readSel(readSel)
  );

  irq_regs_dp #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .readSel(readSel),
    .wrBits(wdata[NUM_SRC-1:0]), .srcIn(srcIn),
    .statusQ(statusQ), .maskQ(maskQ), .rdata(rdata)
  );

  assign irq = |(statusQ & maskQ);

endmodule

// File: rtl/irq_regs_chk.sv
module irq_regs_chk #(
  parameter int NUM_SRC = 7,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] STATUS_OFS  = 'h04,
  parameter logic [ADDR_W-1:0] ENABLE_OFS  = 'h08,
  parameter logic [ADDR_W-1:0] DISABLE_OFS = 'h0C
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wdata,
  input logic [NUM_SRC-1:0] srcIn,
  input logic [NUM_SRC-1:0] statusQ,
  input logic [NUM_SRC-1:0] maskQ,
  input logic               irq
);

  logic wrStatus, wrEnable, wrDisable;
  assign wrStatus  = wrEn && (addr == STATUS_OFS);
  assign wrEnable  = wrEn && (addr == ENABLE_OFS);
  assign wrDisable = wrEn && (addr == DISABLE_OFS);

  p_src_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    (srcIn != '0) |=> ((statusQ & $past(srcIn)) == $past(srcIn)));

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    !wrStatus |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  // R4 folded in: bits still driven by a source are excluded from the clear
  p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrStatus |=> ((statusQ & $past(wdata[NUM_SRC-1:0] & ~srcIn)) == '0));

  p_mask_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrEnable |=> ((maskQ & $past(wdata[NUM_SRC-1:0])) == $past(wdata[NUM_SRC-1:0])));

  p_mask_clr_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrDisable |=> ((maskQ & $past(wdata[NUM_SRC-1:0])) == '0));

  p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEnable || wrDisable) |=> $stable(maskQ));

  p_no_irq_unmasked_r9: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> !irq);

endmodule

bind irq_regs_top irq_regs_chk #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .STATUS_OFS(STATUS_OFS), .ENABLE_OFS(ENABLE_OFS), .DISABLE_OFS(DISABLE_OFS)
) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
  .srcIn(srcIn), .statusQ(statusQ), .maskQ(maskQ), .irq(irq)
);

// File: tb/irq_regs_top_test.sv
`timescale 1ns/1ps
module irq_regs_top_test;

  localparam int NS = 7;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam logic [AW-1:0] A_STAT = 8'h04;
  localparam logic [AW-1:0] A_EN   = 8'h08;
  localparam logic [AW-1:0] A_DIS  = 8'h0C;
  localparam logic [AW-1:0] A_MASK = 8'h10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NS-1:0] srcIn = '0;
  logic          irq;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [DW-1:0] expData;
    logic          expIrq;
    string         tag;
  } probe_t;

  probe_t expQ[$];
  logic   probeValid = 1'b0;
  bit     doneFlag = 1'b0;

  always #5 clk = ~clk;

  irq_regs_top uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .srcIn(srcIn), .irq(irq)
  );

  // Monitor: pops one expected item per probe cycle, after the edge settles
  always @(posedge clk) begin
    #1;
    if (probeValid) begin
      probe_t it;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty: rdata=%h irq=%b", rdata, irq);
      end else begin
        it = expQ.pop_front();
        checks++;
        if (rdata !== it.expData || irq !== it.expIrq) begin
          errors++;
          $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                   it.tag, rdata, irq, it.expData, it.expIrq);
        end
      end
    end
  end

  task automatic regWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0; wdata = '0;
  endtask

  task automatic probe(input logic [AW-1:0] a, input logic [DW-1:0] e,
                       input logic ei, input string tag);
    probe_t it;
    @(negedge clk);
    addr = a;
    it.expData = e; it.expIrq = ei; it.tag = tag;
    expQ.push_back(it);
    probeValid = 1'b1;
    @(negedge clk);
    probeValid = 1'b0;
  endtask

  task automatic pulse(input logic [NS-1:0] bits);
    @(negedge clk);
    srcIn = bits;
    @(negedge clk);
    srcIn = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    probe(A_STAT, 32'h0, 1'b0, "R1 status after reset");
    probe(A_MASK, 32'h0, 1'b0, "R1 mask after reset");

    // R2 mode fault (bit 1) latches; masked off so no irq (R9)
    pulse(7'h02);
    probe(A_STAT, 32'h02, 1'b0, "R2 mode fault latched");

    // R5 enable bit 1 -> R7 mask readback, R9 irq rises
    regWrite(A_EN, 32'h02);
    probe(A_MASK, 32'h02, 1'b1, "R5 R7 mask set");

    // R8 write-only and unmapped offsets read zero
    probe(A_EN,  32'h0, 1'b1, "R8 enable reads zero");
    probe(A_DIS, 32'h0, 1'b1, "R8 disable reads zero");
    probe(8'h00, 32'h0, 1'b1, "R8 unmapped reads zero");

    // R3 zero write keeps status, one write clears
    regWrite(A_STAT, 32'h0);
    probe(A_STAT, 32'h02, 1'b1, "R3 zero write keeps");
    regWrite(A_STAT, 32'h02);
    probe(A_STAT, 32'h0, 1'b0, "R3 R9 write-one clears");

    // R4 level source (rx not empty, bit 4) held over a clearing write
    @(negedge clk); srcIn = 7'h10;
    regWrite(A_STAT, 32'h10);
    probe(A_STAT, 32'h10, 1'b0, "R4 event wins over clear");
    @(negedge clk); srcIn = '0;
    probe(A_STAT, 32'h10, 1'b0, "R2 stays latched after level drops");
    regWrite(A_STAT, 32'h10);
    probe(A_STAT, 32'h0, 1'b0, "R3 cleared after source gone");

    // R5 additive set, R6 selective clear
    regWrite(A_EN, 32'h18);
    probe(A_MASK, 32'h1A, 1'b0, "R5 set keeps other bits");
    regWrite(A_DIS, 32'h02);
    probe(A_MASK, 32'h18, 1'b0, "R6 clear keeps other bits");
    regWrite(A_DIS, 32'h0);
    probe(A_MASK, 32'h18, 1'b0, "R6 zero write no change");

    // R10 mask view is read-only
    regWrite(A_MASK, 32'h7F);
    probe(A_MASK, 32'h18, 1'b0, "R10 mask write ignored");

    // R9 mixed pattern: only bit 3 (tx full) is enabled among the set ones
    pulse(7'h6D);
    probe(A_STAT, 32'h6D, 1'b1, "R2 R9 mixed pattern");
    // R10 enable/disable writes leave status alone
    regWrite(A_DIS, 32'h18);
    probe(A_STAT, 32'h6D, 1'b0, "R10 R9 status kept, irq drops");
    // R7 upper data bits have no effect and read zero
    regWrite(A_EN, 32'hFFFF_FF80);
    probe(A_MASK, 32'h0, 1'b0, "R7 upper bits ignored");
    regWrite(A_STAT, 32'hFFFF_FF80);
    probe(A_STAT, 32'h6D, 1'b0, "R7 upper clear bits ignored");
    regWrite(A_STAT, 32'h6D);
    probe(A_STAT, 32'h0, 1'b0, "R3 full acknowledge");

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard left %0d items", expQ.size());
    end
    doneFlag = 1'b1;
  end

  initial begin
    fork
      wait (doneFlag);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule